// File: doc/BRIEF.md
# Exchange-Aware Register Bank Mapper

This block holds four physical 16-bit registers and presents them under four architectural names: DE, HL and their alternate-bank twins DE' and HL'. Which physical register stands behind each name is decided by three single-bit selectors. These are a bank selector, a selector that picks which half of the active bank acts as HL, and a saved copy of that selector for the inactive bank.

The two exchange operations never copy register contents. Swapping DE with HL inverts the active-bank selector. Swapping banks flips the bank selector and trades the two HL selectors, so each bank keeps its own DE/HL orientation. Between them the two operations reach eight distinct name-to-register mappings. A surrounding decoder drives the name to access, an optional write with its data, and single-cycle exchange strobes. It reads back the value and the physical slot behind the name.

Top module: `regmap_top`

## Requirements
- R1: After reset all three selectors are zero and all four physical registers hold zero. The names then map as follows: HL to slot 0, DE to slot 1, DE' to slot 3, HL' to slot 2.
- R2: Name codes on `regName` are 0 = DE, 1 = HL, 2 = DE', 3 = HL'. HL addresses physical slot {bank, activeSel}, with the bank bit as the upper index bit.
- R3: DE addresses physical slot {bank, not activeSel}.
- R4: HL' addresses slot {not bank, savedSel} and DE' addresses slot {not bank, not savedSel}.
- R5: A DE/HL exchange pulse inverts only activeSel. No stored value changes, so the values read as DE and HL trade places while DE' and HL' are unchanged.
- R6: A bank exchange pulse flips the bank bit and swaps activeSel with savedSel. The values seen under DE and DE' trade places, and so do those under HL and HL'.
- R7: When both pulses arrive in the same cycle, the DE/HL inversion is applied first and the bank exchange second. The result is bank flipped, activeSel taking the old savedSel, and savedSel taking the inverse of the old activeSel.
- R8: A write is taken at the rising clock edge into the slot that the name addressed before any exchange in that same cycle.
- R9: Reads are combinational. `rdData` and `physIdx` follow `regName` and the current selectors within the same cycle, with no clock edge.
- R10: Alternating DE/HL and bank exchanges from reset visits all eight mappings, and in every one of them the four names address four different slots.
- R11: With `wrEn` low no stored value changes. Exchanges move no data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| xchgDeHl | input | 1 | One-cycle strobe: exchange DE with HL in the active bank |
| xchgBanks | input | 1 | One-cycle strobe: exchange the active and alternate banks |
| regName | input | 2 | Architectural name for read and write (0 DE, 1 HL, 2 DE', 3 HL') |
| wrEn | input | 1 | Write the addressed register at the next rising edge |
| wrData | input | 16 | Data to write |
| rdData | output | 16 | Current value of the addressed register |
| physIdx | output | 2 | Physical slot currently addressed by `regName` |

## Verification
Reads carry no latency. `physIdx` and `rdData` are due in the same cycle that `regName` changes, so the bench sets the name on a falling edge and samples a short delay later, with no edge in between. Writes and exchanges each take exactly one rising edge. The bench drives a strobe or write on a falling edge, lets one rising edge pass, then updates its own model of the selectors and slot contents. Every name is checked on the following falling edge. A write paired with an exchange goes into the model using the mapping from before that edge, which is how the pre-exchange write rule is confirmed.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

  localparam int unsigned PHYS_N = 4;
  localparam int unsigned IDX_W  = $clog2(PHYS_N);

  typedef enum logic [1:0] {
    NAME_DE     = 2'd0,
    NAME_HL     = 2'd1,
    NAME_DE_ALT = 2'd2,
    NAME_HL_ALT = 2'd3
  } regName_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [PHYS_N-1:0] wrStrobe;
    logic [IDX_W-1:0]  rdIdx;
  } dpCtl_t;

  // resolve an architectural name to a physical slot
  function automatic logic [IDX_W-1:0] mapName(
    input logic [1:0] name,
    input logic       bankSel,
    input logic       activeSel,
    input logic       savedSel
  );
    logic [IDX_W-1:0] idx;
    unique case (name)
      NAME_HL:     idx = {bankSel,  activeSel};
      NAME_DE:     idx = {bankSel, ~activeSel};
      NAME_HL_ALT: idx = {~bankSel,  savedSel};
      default:     idx = {~bankSel, ~savedSel};
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/regmap_ctrl.sv
module regmap_ctrl
  import regmap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             xchgDeHl,
  input  logic             xchgBanks,
  input  logic [1:0]       regName,
  input  logic             wrEn,
  output dpCtl_t           ctl,
  output logic [IDX_W-1:0] physIdx
);

  logic bankSel, activeSel, savedSel;
  logic bankNext, activeNext, savedNext;
  logic activeAfterDh;
  logic [IDX_W-1:0] curIdx;

  // stage 1: DE/HL inversion, stage 2: bank exchange
  always_comb begin
    activeAfterDh = activeSel ^ xchgDeHl;
    if (xchgBanks) begin
      bankNext   = ~bankSel;
      activeNext = savedSel;
      savedNext  = activeAfterDh;
    end else begin
      bankNext   = bankSel;
      activeNext = activeAfterDh;
      savedNext  = savedSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankSel   <= 1'b0;
      activeSel <= 1'b0;
      savedSel  <= 1'b0;
    end else begin
      bankSel   <= bankNext;
      activeSel <= activeNext;
      savedSel  <= savedNext;
    end
  end

  assign curIdx     = mapName(regName, bankSel, activeSel, savedSel);
  assign physIdx    = curIdx;
  assign ctl.rdIdx  = curIdx;

  for (genvar g = 0; g < PHYS_N; g++) begin : g_strobe
    assign ctl.wrStrobe[g] = wrEn && (curIdx == IDX_W'(g));
  end

  AST_DEHL_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (xchgDeHl && !xchgBanks) |=> (activeSel != $past(activeSel)) && $stable(bankSel) && $stable(savedSel)); // R5

  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (xchgBanks && !xchgDeHl) |=> (bankSel != $past(bankSel)) && (activeSel == $past(savedSel)) && (savedSel == $past(activeSel))); // R6

  AST_BOTH_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (xchgBanks && xchgDeHl) |=> (bankSel != $past(bankSel)) && (activeSel == $past(savedSel)) && (savedSel != $past(activeSel))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!xchgBanks && !xchgDeHl) |=> $stable(bankSel) && $stable(activeSel) && $stable(savedSel)); // R5

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.wrStrobe) && (wrEn || (ctl.wrStrobe == '0))); // R11

endmodule

// File: rtl/regmap_dp.sv
module regmap_dp
  import regmap_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] bank [PHYS_N];

  for (genvar g = 0; g < PHYS_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)                bank[g] <= '0;
      else if (ctl.wrStrobe[g]) bank[g] <= wrData;
    end

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.wrStrobe[g] |=> $stable(bank[g])); // R11

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
      ctl.wrStrobe[g] |=> (bank[g] == $past(wrData))); // R8
  end

  assign rdData = bank[ctl.rdIdx];

endmodule

// File: rtl/regmap_top.sv
module regmap_top
  import regmap_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xchgDeHl,
  input  logic              xchgBanks,
  input  logic [1:0]        regName,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        physIdx
);

  dpCtl_t ctl;

  regmap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .xchgDeHl  (xchgDeHl),
    .xchgBanks (xchgBanks),
    .regName   (regName),
    .wrEn      (wrEn),
    .ctl       (ctl),
    .physIdx   (physIdx)
  );

  regmap_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: tb/regmap_top_tb.sv
module regmap_top_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        xchgDeHl, xchgBanks, wrEn;
  logic [1:0]  regName;
  logic [15:0] wrData, rdData;
  logic [1:0]  physIdx;

  int checks = 0;
  int fails  = 0;

  // bench model of the requirements
  logic        mBank, mAct, mSav;
  logic [15:0] mReg [4];

  always #10 clk = ~clk;

  regmap_top u_dut (
    .clk(clk), .rstN(rstN), .xchgDeHl(xchgDeHl), .xchgBanks(xchgBanks),
    .regName(regName), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .physIdx(physIdx)
  );

  function automatic logic [1:0] expIdx(input logic [1:0] n);
    case (n)
      2'd1:    return {mBank, mAct};
      2'd0:    return {mBank, ~mAct};
      2'd3:    return {~mBank, mSav};
      default: return {~mBank, ~mSav};
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock with given strobes; model updates after the edge
  task automatic step(input logic dh, input logic bk, input logic we,
                      input logic [1:0] n, input logic [15:0] d);
    logic a1;
    xchgDeHl = dh; xchgBanks = bk; wrEn = we; regName = n; wrData = d;
    @(posedge clk);
    if (we) mReg[expIdx(n)] = d;
    a1 = mAct ^ dh;
    if (bk) begin
      mBank = ~mBank; mAct = mSav; mSav = a1;
    end else mAct = a1;
    @(negedge clk);
    xchgDeHl = 0; xchgBanks = 0; wrEn = 0;
  endtask

  task automatic checkAll(input string req);
    for (int n = 0; n < 4; n++) begin
      regName = n[1:0];
      #1;
      check({req, " idx"}, int'(physIdx), int'(expIdx(n[1:0])));
      check({req, " data"}, int'(rdData), int'(mReg[expIdx(n[1:0])]));
    end
  endtask

  task automatic doReset();
    rstN = 0; xchgDeHl = 0; xchgBanks = 0; wrEn = 0; regName = 0; wrData = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rstN = 1;
    mBank = 0; mAct = 0; mSav = 0;
    for (int i = 0; i < 4; i++) mReg[i] = '0;
  endtask

  task automatic tReset();
    doReset();
    regName = 2'd1; #1; check("R1 HL slot", int'(physIdx), 0);
    regName = 2'd0; #1; check("R1 DE slot", int'(physIdx), 1);
    regName = 2'd2; #1; check("R1 DE' slot", int'(physIdx), 3);
    regName = 2'd3; #1; check("R1 HL' slot", int'(physIdx), 2);
    checkAll("R1 zero");
  endtask

  task automatic tWriteAll();
    step(0, 0, 1, 2'd0, 16'h1111);
    step(0, 0, 1, 2'd1, 16'h2222);
    step(0, 0, 1, 2'd2, 16'h3333);
    step(0, 0, 1, 2'd3, 16'h4444);
    checkAll("R2 R3 R4 write/read");
  endtask

  task automatic tCombRead();
    // R9: no edge between name change and sample
    regName = 2'd1; #1; check("R9 HL read", int'(rdData), 16'h2222);
    regName = 2'd2; #1; check("R9 DE' read", int'(rdData), 16'h3333);
  endtask

  task automatic tXchgDeHl();
    step(1, 0, 0, 2'd0, 16'h0);
    regName = 2'd0; #1; check("R5 DE after swap", int'(rdData), 16'h2222);
    regName = 2'd1; #1; check("R5 HL after swap", int'(rdData), 16'h1111);
    regName = 2'd3; #1; check("R5 HL' unchanged", int'(rdData), 16'h4444);
    checkAll("R5");
  endtask

  task automatic tXchgBanks();
    step(0, 1, 0, 2'd0, 16'h0);
    regName = 2'd1; #1; check("R6 HL now old HL'", int'(rdData), 16'h4444);
    regName = 2'd0; #1; check("R6 DE now old DE'", int'(rdData), 16'h3333);
    checkAll("R6");
    step(0, 1, 0, 2'd0, 16'h0);
    regName = 2'd1; #1; check("R6 back, orientation kept", int'(rdData), 16'h1111);
    checkAll("R6 return");
  endtask

  task automatic tBoth();
    step(1, 1, 0, 2'd0, 16'h0);
    checkAll("R7 both pulses");
    step(1, 1, 0, 2'd0, 16'h0);
    checkAll("R7 both pulses again");
  endtask

  task automatic tWriteWithXchg();
    logic [1:0] oldHl;
    oldHl = expIdx(2'd1);
    step(1, 0, 1, 2'd1, 16'hABCD);
    regName = 2'd0; #1;
    check("R8 write used pre-swap HL slot", int'(physIdx), int'(oldHl));
    check("R8 value under DE", int'(rdData), 16'hABCD);
    step(0, 1, 1, 2'd3, 16'h5A5A);
    checkAll("R8 write with bank swap");
    step(1, 1, 1, 2'd2, 16'hC3C3);
    checkAll("R8 write with both");
  endtask

  task automatic tNoWrite();
    step(0, 0, 0, 2'd1, 16'hDEAD);
    step(0, 0, 0, 2'd0, 16'hBEEF);
    checkAll("R11 wrEn low");
  endtask

  task automatic tPerms();
    logic [7:0] code;
    logic seen [256];
    int distinct;
    int clash;
    doReset();
    for (int i = 0; i < 256; i++) seen[i] = 1'b0;
    distinct = 0;
    for (int s = 0; s < 8; s++) begin
      logic [1:0] ix [4];
      for (int n = 0; n < 4; n++) begin
        regName = n[1:0]; #1; ix[n] = physIdx;
        check("R10 mapping", int'(physIdx), int'(expIdx(n[1:0])));
      end
      clash = 0;
      for (int p = 0; p < 4; p++)
        for (int q = p + 1; q < 4; q++)
          if (ix[p] == ix[q]) clash++;
      check("R10 bijective", clash, 0);
      code = {ix[0], ix[1], ix[2], ix[3]};
      if (!seen[code]) begin seen[code] = 1'b1; distinct++; end
      if (s % 2 == 0) step(1, 0, 0, 2'd0, 16'h0);
      else            step(0, 1, 0, 2'd0, 16'h0);
    end
    check("R10 distinct mappings", distinct, 8);
    checkAll("R10 back at start");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tReset();
    tWriteAll();
    tCombRead();
    tXchgDeHl();
    tXchgBanks();
    tBoth();
    tWriteWithXchg();
    tNoWrite();
    tPerms();
    tReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule